// File: doc/BRIEF.md
# Debug burst-write receiver with bit-serial CRC

This block sits behind a JTAG data register and turns a debug burst-write into a series of write requests. It takes one command scan of 53 bits. The command holds a module flag, a write opcode, a 32-bit start address and a 16-bit word count. After the command it waits for a single 1 start bit. It then gathers data words of 1, 2 or 4 bytes, least significant bit first, and hands each finished word to a simple write-request interface together with its address and byte size.

A checksum runs alongside the data. It is updated one bit per shift with a reflected 32-bit polynomial. After the last word the host shifts in a 32-bit checksum. The block compares it with its own value and returns a single match bit on the serial output. Writes go out as soon as their word completes. A checksum mismatch only clears the match bit; it does not undo any write. A pulse on `cmd_begin` starts a fresh command at any time. It abandons whatever burst was in progress and resets the checksum register.

Top module: `burst_wr_rx`

## Requirements
- R1: After reset, `wr_req`, `resp_vld` and `bit_out` are 0, and the block waits for `cmd_begin`.
- R2: After `cmd_begin`, the next 53 shifted bits (bit_vld high) form the command, least significant bit first. Bits 15:0 are the word count, bits 47:16 the start address, bits 51:48 the opcode and bit 52 the module flag. Opcode 1, 2 and 3 select 1-, 2- and 4-byte words. A command whose flag is 1 or whose opcode is any other value is ignored: no write and no response follow.
- R3: A command with a word count of 0, or above MAX_WORDS (default 4096), is ignored. A count equal to MAX_WORDS is accepted.
- R4: After an accepted command, shifted 0 bits are skipped. The first shifted 1 is the start bit, and the data begins with the next shifted bit.
- R5: Each word is 8, 16 or 32 shifted bits, least significant bit first, so that bytes arrive in little-endian order. `wr_data` carries the word zero-extended to 32 bits, and `wr_bytes` carries 1, 2 or 4.
- R6: `wr_req` is high for exactly one cycle, the cycle after the word's last bit is shifted. The first word carries the command address, and each later word carries the previous address plus the word size in bytes.
- R7: The checksum starts at 0xFFFFFFFF. For each data bit the register shifts right by one, and it is XORed with 0xEDB88320 when the data bit XOR the old bit 0 is 1. The 32 bits shifted after the last word are the received checksum, least significant bit first. From the cycle after the last of them, `resp_vld` is 1 and `bit_out` equals 1 if the two checksums match. This holds until the next shift.
- R8: On a mismatch `bit_out` is 0 during the response. Writes already issued in that burst stand.
- R9: `cmd_begin` in any state abandons the current burst at once: no further write or response from it. If `cmd_begin` and `bit_vld` are high in the same cycle, the bit is dropped.
- R10: Cycles with `bit_vld` low change nothing: no write is issued and the position within the command, word or checksum is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_begin | input | 1 | Pulse: abandon any burst and start collecting a command |
| bit_vld | input | 1 | A serial bit is shifted this cycle |
| bit_in | input | 1 | Serial input bit |
| bit_out | output | 1 | Serial output: the checksum match bit while resp_vld is high, else 0 |
| resp_vld | output | 1 | The match bit is being presented |
| wr_req | output | 1 | One-cycle write request |
| wr_addr | output | 32 | Byte address of the write |
| wr_data | output | 32 | Write data, zero-extended |
| wr_bytes | output | 3 | Write size in bytes (1, 2 or 4) |

## Verification
Bursts are driven in each of the three word sizes. The 32-bit case shows the byte order and the address stride. The 8-bit case mixes idle cycles and leading zeros before the start bit, which separates the start-bit search and the stall behaviour from a plain back-to-back stream. A 16-bit burst with a corrupted checksum shows that a mismatch leaves the writes in place, and a 4096-word byte burst probes the count limit. Commands with a bad opcode, a set module flag, a zero count or an oversized count are each followed by 1 bits, so that a block wrongly accepting them would issue writes. A burst cut short by a new command shows the abort, and the clean burst after it shows that the checksum was reset.

// File: rtl/burst_wr_rx.sv
module burst_wr_rx #(
  parameter int MAX_WORDS = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_begin,
  input  logic        bit_vld,
  input  logic        bit_in,
  output logic        bit_out,
  output logic        resp_vld,
  output logic        wr_req,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  output logic [2:0]  wr_bytes
);
  localparam int LEN_W    = 16;
  localparam int ADDR_W   = 32;
  localparam int OP_W     = 4;
  localparam int CMD_BITS = LEN_W + ADDR_W + OP_W + 1;
  localparam int CRC_W    = 32;
  localparam logic [CRC_W-1:0] POLY = 32'hEDB88320;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_WAIT, S_DATA, S_CRC, S_RESP} st_t;

  st_t               st;
  logic [CMD_BITS-1:0] cmd_sr;
  logic [5:0]        bcnt;
  logic [LEN_W-1:0]  words_left;
  logic [ADDR_W-1:0] addr;
  logic [2:0]        bytes;
  logic [31:0]       word_sr;
  logic [CRC_W-1:0]  crc;
  logic [CRC_W-1:0]  rx_crc;
  logic              match;

  logic [CMD_BITS-1:0] cmd_next;
  logic [2:0]          dec_bytes;
  logic [LEN_W-1:0]    dec_len;
  logic                cmd_ok;
  logic [31:0]         word_next;
  logic [31:0]         aligned;
  logic [5:0]          word_bits;
  logic                word_last;
  logic [CRC_W-1:0]    crc_next;
  logic [CRC_W-1:0]    rx_next;

  assign cmd_next  = {bit_in, cmd_sr[CMD_BITS-1:1]};
  assign dec_len   = cmd_next[LEN_W-1:0];
  assign word_next = {bit_in, word_sr[31:1]};
  assign word_bits = {bytes, 3'b000};
  assign word_last = (bcnt == word_bits - 6'd1);
  assign crc_next  = (crc >> 1) ^ (((crc[0] ^ bit_in) != 1'b0) ? POLY : '0);
  assign rx_next   = {bit_in, rx_crc[CRC_W-1:1]};

  always_comb begin
    case (cmd_next[LEN_W+ADDR_W +: OP_W])
      4'h1:    dec_bytes = 3'd1;
      4'h2:    dec_bytes = 3'd2;
      4'h3:    dec_bytes = 3'd4;
      default: dec_bytes = 3'd0;
    endcase
  end

  assign cmd_ok = !cmd_next[CMD_BITS-1] && (dec_bytes != 3'd0) &&
                  (dec_len != '0) && (32'(dec_len) <= MAX_WORDS);

  always_comb begin
    case (bytes)
      3'd1:    aligned = {24'd0, word_next[31:24]};
      3'd2:    aligned = {16'd0, word_next[31:16]};
      default: aligned = word_next;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cmd_sr     <= '0;
      bcnt       <= '0;
      words_left <= '0;
      addr       <= '0;
      bytes      <= '0;
      word_sr    <= '0;
      crc        <= '1;
      rx_crc     <= '0;
      match      <= 1'b0;
      wr_req     <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      wr_bytes   <= '0;
    end else begin
      wr_req <= 1'b0;
      if (cmd_begin) begin
        st   <= S_CMD;
        bcnt <= '0;
        crc  <= '1;
      end else if (bit_vld) begin
        case (st)
          S_CMD: begin
            cmd_sr <= cmd_next;
            bcnt   <= bcnt + 6'd1;
            if (bcnt == 6'(CMD_BITS - 1)) begin
              bcnt <= '0;
              if (cmd_ok) begin
                st         <= S_WAIT;
                addr       <= cmd_next[LEN_W +: ADDR_W];
                bytes      <= dec_bytes;
                words_left <= dec_len;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_WAIT: begin
            if (bit_in) begin
              st   <= S_DATA;
              bcnt <= '0;
            end
          end
          S_DATA: begin
            crc     <= crc_next;
            word_sr <= word_next;
            if (word_last) begin
              wr_req     <= 1'b1;
              wr_addr    <= addr;
              wr_data    <= aligned;
              wr_bytes   <= bytes;
              addr       <= addr + {29'd0, bytes};
              words_left <= words_left - 1'b1;
              bcnt       <= '0;
              if (words_left == 1) st <= S_CRC;
            end else begin
              bcnt <= bcnt + 6'd1;
            end
          end
          S_CRC: begin
            rx_crc <= rx_next;
            bcnt   <= bcnt + 6'd1;
            if (bcnt == 6'(CRC_W - 1)) begin
              match <= (rx_next == crc);
              st    <= S_RESP;
            end
          end
          S_RESP:  st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign resp_vld = (st == S_RESP);
  assign bit_out  = resp_vld & match;

  a_r6_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);
  a_r5_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_bytes == 3'd1 || wr_bytes == 3'd2 || wr_bytes == 3'd4));
  a_r7_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_vld && !bit_vld && !cmd_begin) |=> resp_vld);
  a_r7_out_only_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
    bit_out |-> resp_vld);
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_begin |=> (!resp_vld && !wr_req));
  a_r10_no_shift_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !cmd_begin) |=> !wr_req);
  a_r10_resp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_vld && !bit_vld && !cmd_begin) |=> $stable(bit_out));
endmodule

// File: tb/burst_wr_rx_tb.sv
module burst_wr_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_begin = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
  logic bit_out, resp_vld, wr_req;
  logic [31:0] wr_addr, wr_data;
  logic [2:0]  wr_bytes;

  always #2 clk = ~clk;

  burst_wr_rx u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_begin(cmd_begin), .bit_vld(bit_vld),
    .bit_in(bit_in), .bit_out(bit_out), .resp_vld(resp_vld), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_bytes(wr_bytes)
  );

  int total = 0, bad = 0, nwr = 0;
  logic seen_resp = 1'b0, seen_match = 1'b0;

  // behavioural model
  int m_phase = 0, m_cnt = 0, m_size = 0, m_left = 0;
  longint unsigned m_cmd = 0;
  logic [31:0] m_addr = 0, m_word = 0, m_rx = 0;
  logic [7:0] m_bytes[$];
  logic e_wr = 0, e_resp = 0, e_match = 0;
  logic [31:0] e_addr = 0, e_data = 0;
  logic [2:0]  e_size = 0;

  function automatic logic [31:0] crc_of(input logic [7:0] q[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (q[i]) for (int k = 0; k < 8; k++)
      c = (c >> 1) ^ ((c[0] ^ q[i][k]) ? 32'hEDB8_8320 : 32'h0);
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(wr_req === e_wr, "R6 wr_req", 32'(wr_req), 32'(e_wr));
    if (e_wr && wr_req) begin
      chk(wr_addr === e_addr, "R6 wr_addr", wr_addr, e_addr);
      chk(wr_data === e_data, "R5 wr_data", wr_data, e_data);
      chk(wr_bytes === e_size, "R5 wr_bytes", 32'(wr_bytes), 32'(e_size));
    end
    chk(resp_vld === e_resp, "R7 resp_vld", 32'(resp_vld), 32'(e_resp));
    chk(bit_out === (e_resp & e_match), e_match ? "R7 bit_out" : "R8 bit_out",
        32'(bit_out), 32'(e_resp & e_match));
    if (wr_req === 1'b1) nwr++;
    if (resp_vld === 1'b1) begin seen_resp = 1'b1; seen_match = bit_out; end
  endtask

  task automatic model(input logic c, input logic v, input logic b);
    e_wr = 1'b0;
    if (c) begin
      m_phase = 1; m_cnt = 0; m_cmd = 0; m_bytes.delete(); e_resp = 1'b0;
    end else if (v) begin
      case (m_phase)
        1: begin
          if (b) m_cmd |= (64'd1 << m_cnt);
          m_cnt++;
          if (m_cnt == 53) begin
            m_left = int'(m_cmd & 64'hFFFF);
            m_addr = 32'(m_cmd >> 16);
            case (int'((m_cmd >> 48) & 64'hF))
              1: m_size = 1; 2: m_size = 2; 3: m_size = 4; default: m_size = 0;
            endcase
            if (m_cmd[52] || m_size == 0 || m_left == 0 || m_left > 4096) m_phase = 0;
            else m_phase = 2;
          end
        end
        2: if (b) begin m_phase = 3; m_cnt = 0; m_word = 0; end
        3: begin
          m_word[m_cnt] = b;
          m_cnt++;
          if (m_cnt == 8 * m_size) begin
            e_wr = 1'b1; e_addr = m_addr; e_data = m_word; e_size = 3'(m_size);
            for (int k = 0; k < m_size; k++) m_bytes.push_back(m_word[8*k +: 8]);
            m_addr += 32'(m_size); m_left--; m_cnt = 0; m_word = 0;
            if (m_left == 0) begin m_phase = 4; m_rx = 0; end
          end
        end
        4: begin
          m_rx[m_cnt] = b;
          m_cnt++;
          if (m_cnt == 32) begin
            m_phase = 5; e_resp = 1'b1; e_match = (m_rx == crc_of(m_bytes));
          end
        end
        5: begin m_phase = 0; e_resp = 1'b0; end
        default: ;
      endcase
    end
  endtask

  task automatic step(input logic c, input logic v, input logic b);
    @(negedge clk);
    compare();
    cmd_begin = c; bit_vld = v; bit_in = b;
    model(c, v, b);
  endtask

  task automatic send_cmd(input logic flag, input logic [3:0] op, input logic [31:0] a, input logic [15:0] len);
    logic [52:0] w = {flag, op, a, len};
    step(1, 0, 0);
    for (int i = 0; i < 53; i++) step(0, 1, w[i]);
  endtask

  // sends start bit, bytes, checksum (xor corrupt), then lets the response show
  task automatic send_payload(input logic [7:0] q[$], input int lead0, input bit gaps, input logic [31:0] corrupt);
    logic [31:0] c = crc_of(q) ^ corrupt;
    for (int i = 0; i < lead0; i++) step(0, 1, 0);
    step(0, 1, 1);
    foreach (q[i]) for (int k = 0; k < 8; k++) begin
      step(0, 1, q[i][k]);
      if (gaps && (k % 3 == 0)) step(0, 0, 1);
    end
    for (int k = 0; k < 32; k++) step(0, 1, c[k]);
    seen_resp = 1'b0;
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    step(0, 1, 0); step(0, 0, 0);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(wr_req === 1'b0 && resp_vld === 1'b0 && bit_out === 1'b0, "R1 reset", {wr_req, resp_vld, bit_out}, 0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0);

    // 32-bit words, good checksum (R5 R6 R7)
    nwr = 0; q.delete();
    for (int i = 0; i < 12; i++) q.push_back(8'(8'h11 * i + 8'h05));
    send_cmd(0, 4'h3, 32'h0000_1000, 16'd3);
    send_payload(q, 0, 0, 32'h0);
    chk(nwr == 3, "R6 count32", nwr, 3);
    chk(seen_resp && seen_match, "R7 match32", {seen_resp, seen_match}, 2'b11);

    // 8-bit words, leading zeros and idle gaps (R4 R10)
    nwr = 0; q.delete();
    for (int i = 0; i < 5; i++) q.push_back(8'(8'hA3 ^ (i * 37)));
    send_cmd(0, 4'h1, 32'hFFFF_FFFE, 16'd5);
    send_payload(q, 7, 1, 32'h0);
    chk(nwr == 5, "R4 count8", nwr, 5);
    chk(seen_resp && seen_match, "R10 match8", {seen_resp, seen_match}, 2'b11);

    // 16-bit words, corrupted checksum: writes stand, match 0 (R8)
    nwr = 0; q.delete();
    for (int i = 0; i < 8; i++) q.push_back(8'(i * 29 + 1));
    send_cmd(0, 4'h2, 32'h2000_0002, 16'd4);
    send_payload(q, 2, 0, 32'h0001_0000);
    chk(nwr == 4, "R8 writes kept", nwr, 4);
    chk(seen_resp && !seen_match, "R8 mismatch", {seen_resp, seen_match}, 2'b10);

    // ignored commands followed by ones (R2 R3)
    nwr = 0; seen_resp = 1'b0;
    send_cmd(0, 4'h5, 32'h10, 16'd2);
    for (int i = 0; i < 80; i++) step(0, 1, 1);
    chk(nwr == 0 && !seen_resp, "R2 bad opcode", nwr, 0);
    send_cmd(1, 4'h3, 32'h10, 16'd2);
    for (int i = 0; i < 80; i++) step(0, 1, 1);
    chk(nwr == 0 && !seen_resp, "R2 flag set", nwr, 0);
    send_cmd(0, 4'h1, 32'h10, 16'd0);
    for (int i = 0; i < 80; i++) step(0, 1, 1);
    chk(nwr == 0 && !seen_resp, "R3 zero count", nwr, 0);
    send_cmd(0, 4'h1, 32'h10, 16'd4097);
    for (int i = 0; i < 80; i++) step(0, 1, 1);
    chk(nwr == 0 && !seen_resp, "R3 over limit", nwr, 0);

    // abort mid-burst, then a clean burst (R9)
    nwr = 0;
    send_cmd(0, 4'h3, 32'h3000, 16'd4);
    step(0, 1, 1);
    for (int i = 0; i < 42; i++) step(0, 1, i[0]);
    q.delete();
    for (int i = 0; i < 4; i++) q.push_back(8'(8'hC0 + i));
    send_cmd(0, 4'h2, 32'h4000, 16'd2);
    send_payload(q, 0, 0, 32'h0);
    chk(nwr == 3, "R9 abort count", nwr, 3);
    chk(seen_resp && seen_match, "R9 crc reset", {seen_resp, seen_match}, 2'b11);

    // count at the limit (R3)
    nwr = 0; q.delete();
    for (int i = 0; i < 4096; i++) q.push_back(8'(i * 7 + 3));
    send_cmd(0, 4'h1, 32'h8000_0000, 16'd4096);
    send_payload(q, 0, 0, 32'h0);
    chk(nwr == 4096, "R3 max count", nwr, 4096);
    chk(seen_resp && seen_match, "R3 max match", {seen_resp, seen_match}, 2'b11);

    step(0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule